// File: doc/BRIEF.md
# Emulation Scan-Cycle Sequencer

This block paces a circuit that is emulated from a program held in a word memory. Each trip round its loop is one clock of the emulated circuit. After reset it walks the whole program once and zeroes the value bit of every write word, so every emulated state starts at 0. Then it repeats a fixed loop:

- Stage the present states for output.
- Load the peripheral input bits into the direct-read words.
- Copy each next state into the direct-read word that names it.
- Hand the memory to an external expression evaluator and wait for it.
- Stage the computed non-state outputs.
- Ask an external output writer to drive the ports.
- Wait a user-set number of delay units before starting the next loop.

Each program word is 16 bits. Bit 15 set marks a function word, which the sequencer never changes. Otherwise:

- Bits 14:13 are the kind: 00 direct read, 01 indirect read, 10 plain write, 11 state write.
- Bits 12:9 are the location. For a direct read it selects an input bit, 1 to 14, or 0 for a state read. For a write it selects an output bit, 1 to 14, or 0 for an internal node.
- Bits 8:1 are the link. For an input read it is the port address placed on the input bus. For a state read it is the program index of the state write it copies.
- Bit 0 is the value.

Location n maps to bit n-1 of the input bus or of the staging vector.

State machine:

- **INIT**: walks every word, then goes to STG_ST.
- **STG_ST**: walks every word, then goes to LD_IN.
- **LD_IN**: walks every word, then goes to CP_SCAN.
- **CP_SCAN**: on a state read it goes to CP_FETCH. Otherwise it steps to the next word, and goes to EV_GO after the last word.
- **CP_FETCH**: reads the linked state write, then goes to CP_WR.
- **CP_WR**: writes the fetched value back into the state read. It returns to CP_SCAN, or goes to EV_GO after the last word.
- **EV_GO**: one cycle, then EV_WT.
- **EV_WT**: waits for the evaluator's done, then goes to STG_CB.
- **STG_CB**: walks every word, then goes to OUT_GO.
- **OUT_GO**: one cycle, then OUT_WT.
- **OUT_WT**: waits for the writer's done, then goes to DL_GO.
- **DL_GO**: one cycle, then DL_WT.
- **DL_WT**: waits for the delay to finish, then goes back to STG_ST.

Top module: `emu_scan_seq`

## Requirements
- R1: After reset, before the first evaluation, every plain-write and state-write word has bit 0 cleared. All its other bits and all other words are kept.
- R2: Within every loop, the three update passes run in a fixed order: present states are staged, then inputs are loaded, then next states are copied. Each pass covers the whole program before the next one starts.
- R3: A direct-read word with location 1 to 14 gets, in bit 0, bit location-1 of `in_rdata`. The bus is read while `in_addr` equals the word's link.
- R4: A direct-read word with location 0 gets, in bit 0, the value bit of the word at the program index given by its link.
- R5: Before evaluation, each state write with location 1 to 14 copies its value, which is the present state, into staging bit location-1.
- R6: After evaluation, each plain write with location 1 to 14 copies its value into staging bit location-1. A write with location 0 changes no staging bit. `stage_data` is held steady while the output writer runs.
- R7: `eval_start` and `out_start` are one-cycle pulses. The sequencer waits for the matching done, and it issues no memory write while the evaluator runs.
- R8: For a delay setting of u, counted from 0 to 9999, the delay wait lasts exactly u × TICK_DIV clock cycles longer than for u = 0.
- R9: `cycle_count` is 0 after reset and rises by exactly one at the end of each loop.
- R10: An input change made during evaluation does not affect that loop's outputs. It appears in the next loop.
- R11: Function words and indirect-read words are never modified.
- R12: A synchronous reset in mid-loop returns the block to INIT. It clears `stage_data` and `cycle_count`, and the write values are cleared again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | PA_W | Program memory word index |
| mem_rdata | input | 16 | Word at `mem_addr`, combinational read |
| mem_we | output | 1 | Write strobe for the word at `mem_addr` |
| mem_wdata | output | 16 | Word to write |
| in_addr | output | 8 | Input port address (link of the current word) |
| in_rdata | input | IN_W | Bits read from the addressed input port |
| eval_start | output | 1 | One-cycle request to the evaluator |
| eval_done | input | 1 | Evaluator finished |
| out_start | output | 1 | One-cycle request to the output writer |
| out_done | input | 1 | Output writer finished |
| stage_data | output | OUT_W | Output staging vector |
| dly_units | input | DLY_W | Delay length in units |
| cycle_count | output | CNT_W | Completed loops |

## Verification
The bench builds the block with a ten-word program and TICK_DIV = 4, so each delay unit costs four cycles. This keeps even the largest setting, 9999 units, inside a short run, and it makes the difference in loop length an exact multiple the bench can compute. The program holds both input reads, at locations 1, 2 and 14, a state read, an internal write at location 0, and one function word and one indirect word. A misread kind field or range check therefore shows up in the staged outputs or in the memory. Ten loops sweep all eight input combinations, with a toggle state computed in the bench, and one of them changes an input during evaluation. A reset in mid-loop follows.

// File: rtl/emu_scan_pkg.sv
package emu_scan_pkg;
    localparam int WORD_W = 16;
    localparam int LOC_W  = 4;
    localparam int LINK_W = 8;

    typedef enum logic [1:0] {
        K_RD_DIRECT   = 2'b00,
        K_RD_INDIRECT = 2'b01,
        K_WR_PLAIN    = 2'b10,
        K_WR_STATE    = 2'b11
    } rw_kind_e;

    typedef struct packed {
        logic              is_func;
        rw_kind_e          kind;
        logic [LOC_W-1:0]  loc;
        logic [LINK_W-1:0] link;
        logic              val;
    } prog_word_t;

    typedef enum logic [3:0] {
        S_INIT, S_STG_ST, S_LD_IN, S_CP_SCAN, S_CP_FETCH, S_CP_WR,
        S_EV_GO, S_EV_WT, S_STG_CB, S_OUT_GO, S_OUT_WT, S_DL_GO, S_DL_WT
    } scan_state_e;
endpackage

// File: rtl/emu_tick_prescaler.sv
module emu_tick_prescaler #(
    parameter int DIV = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int PW = $clog2(DIV + 1);

    logic [PW-1:0] cnt_q;

    assign tick = (cnt_q == PW'(DIV - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R8: the prescaler never leaves its divide range
    a_r8_prescale_bound: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < DIV);
endmodule

// File: rtl/emu_delay_timer.sv
module emu_delay_timer #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] units,
    input  logic         tick,
    output logic         done
);
    logic         busy_q;
    logic [W-1:0] left_q;

    assign done = busy_q && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            left_q <= units;
        end else if (busy_q) begin
            if (left_q == '0) begin
                busy_q <= 1'b0;
            end else if (tick) begin
                left_q <= left_q - 1'b1;
            end
        end
    end

    // R8: while a delay runs the remaining count only goes down
    a_r8_count_down: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && !$past(start)) |-> (left_q <= $past(left_q)));
endmodule

// File: rtl/emu_scan_seq.sv
module emu_scan_seq
    import emu_scan_pkg::*;
#(
    parameter int PROG_LEN = 64,
    parameter int IN_W     = 14,
    parameter int OUT_W    = 14,
    parameter int DLY_W    = 14,
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 3000,
    localparam int PA_W    = (PROG_LEN > 1) ? $clog2(PROG_LEN) : 1
) (
    input  logic                clk,
    input  logic                rst,
    output logic [PA_W-1:0]     mem_addr,
    input  logic [WORD_W-1:0]   mem_rdata,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_wdata,
    output logic [LINK_W-1:0]   in_addr,
    input  logic [IN_W-1:0]     in_rdata,
    output logic                eval_start,
    input  logic                eval_done,
    output logic                out_start,
    input  logic                out_done,
    output logic [OUT_W-1:0]    stage_data,
    input  logic [DLY_W-1:0]    dly_units,
    output logic [CNT_W-1:0]    cycle_count
);
    localparam int OIDX_W = (OUT_W > 1) ? $clog2(OUT_W) : 1;
    localparam int IIDX_W = (IN_W > 1) ? $clog2(IN_W) : 1;

    scan_state_e       state_q, state_d;
    prog_word_t        cur, held_q;
    logic [PA_W-1:0]   idx_q, idx_next;
    logic              fetched_q;
    logic [OUT_W-1:0]  stage_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              at_last, is_rw, st_read, in_read, out_ok;
    logic [OIDX_W-1:0] oidx;
    logic [IIDX_W-1:0] iidx;
    logic              dly_start, dly_done, tick;

    assign cur      = prog_word_t'(mem_rdata);
    assign at_last  = (idx_q == PA_W'(PROG_LEN - 1));
    assign idx_next = at_last ? '0 : idx_q + 1'b1;
    assign is_rw    = !cur.is_func;
    assign st_read  = is_rw && (cur.kind == K_RD_DIRECT) && (cur.loc == '0);
    assign in_read  = is_rw && (cur.kind == K_RD_DIRECT) && (cur.loc != '0)
                      && (int'(cur.loc) <= IN_W);
    assign out_ok   = (cur.loc != '0) && (int'(cur.loc) <= OUT_W);
    assign oidx     = OIDX_W'(cur.loc - 1'b1);
    assign iidx     = IIDX_W'(cur.loc - 1'b1);

    assign stage_data  = stage_q;
    assign cycle_count = cnt_q;

    emu_tick_prescaler #(.DIV(TICK_DIV)) u_prescale (
        .clk   (clk),
        .rst   (rst),
        .clear (dly_start),
        .tick  (tick)
    );

    emu_delay_timer #(.W(DLY_W)) u_delay (
        .clk   (clk),
        .rst   (rst),
        .start (dly_start),
        .units (dly_units),
        .tick  (tick),
        .done  (dly_done)
    );

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_INIT:     if (at_last) state_d = S_STG_ST;
            S_STG_ST:   if (at_last) state_d = S_LD_IN;
            S_LD_IN:    if (at_last) state_d = S_CP_SCAN;
            S_CP_SCAN:  if (st_read) state_d = S_CP_FETCH;
                        else if (at_last) state_d = S_EV_GO;
            S_CP_FETCH: state_d = S_CP_WR;
            S_CP_WR:    state_d = at_last ? S_EV_GO : S_CP_SCAN;
            S_EV_GO:    state_d = S_EV_WT;
            S_EV_WT:    if (eval_done) state_d = S_STG_CB;
            S_STG_CB:   if (at_last) state_d = S_OUT_GO;
            S_OUT_GO:   state_d = S_OUT_WT;
            S_OUT_WT:   if (out_done) state_d = S_DL_GO;
            S_DL_GO:    state_d = S_DL_WT;
            S_DL_WT:    if (dly_done) state_d = S_STG_ST;
            default:    state_d = S_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_INIT;
        else     state_q <= state_d;
    end

    // walk index, staging and loop counter
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            held_q    <= '0;
            fetched_q <= 1'b0;
            stage_q   <= '0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                S_INIT, S_LD_IN: idx_q <= idx_next;
                S_STG_ST: begin
                    if (is_rw && (cur.kind == K_WR_STATE) && out_ok)
                        stage_q[oidx] <= cur.val;
                    idx_q <= idx_next;
                end
                S_STG_CB: begin
                    if (is_rw && (cur.kind == K_WR_PLAIN) && out_ok)
                        stage_q[oidx] <= cur.val;
                    idx_q <= idx_next;
                end
                S_CP_SCAN: begin
                    if (st_read) held_q <= cur;
                    else         idx_q  <= idx_next;
                end
                S_CP_FETCH: fetched_q <= mem_rdata[0];
                S_CP_WR:    idx_q     <= idx_next;
                S_DL_WT:    if (dly_done) cnt_q <= cnt_q + 1'b1;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_addr   = idx_q;
        mem_we     = 1'b0;
        mem_wdata  = mem_rdata;
        in_addr    = cur.link;
        eval_start = 1'b0;
        out_start  = 1'b0;
        dly_start  = 1'b0;
        unique case (state_q)
            S_INIT: if (is_rw && cur.kind[1]) begin
                mem_we    = 1'b1;
                mem_wdata = {mem_rdata[WORD_W-1:1], 1'b0};
            end
            S_LD_IN: if (in_read) begin
                mem_we    = 1'b1;
                mem_wdata = {mem_rdata[WORD_W-1:1], in_rdata[iidx]};
            end
            S_CP_FETCH: mem_addr = PA_W'(held_q.link);
            S_CP_WR: begin
                mem_we    = 1'b1;
                mem_wdata = {held_q[WORD_W-1:1], fetched_q};
            end
            S_EV_GO:  eval_start = 1'b1;
            S_OUT_GO: out_start  = 1'b1;
            S_DL_GO:  dly_start  = 1'b1;
            default: ;
        endcase
    end

    // R7: request pulses last one cycle
    a_r7_eval_pulse: assert property (@(posedge clk) disable iff (rst)
        eval_start |=> !eval_start);
    a_r7_out_pulse: assert property (@(posedge clk) disable iff (rst)
        out_start |=> !out_start);
    // R7: the evaluator owns the memory while it runs
    a_r7_quiet_eval: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_EV_WT) |-> !mem_we);
    // R6: staging is steady while the output writer works
    a_r6_stage_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_OUT_WT) |-> $stable(stage_data));
    // R9: loop counter only steps by one
    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (cycle_count != $past(cycle_count)) |-> (cycle_count == $past(cycle_count) + 1'b1));
    // R2: evaluation is only requested after the copy pass
    a_r2_order: assert property (@(posedge clk) disable iff (rst)
        eval_start |-> ($past(state_q) == S_CP_SCAN || $past(state_q) == S_CP_WR));
endmodule

// File: tb/emu_scan_seq_tb.sv
`timescale 1ns/1ps
module emu_scan_seq_tb_top;
    localparam int PL  = 10;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  mem_addr;
    logic [15:0] mem_rdata;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [7:0]  in_addr;
    logic [13:0] in_rdata;
    logic        eval_start, eval_done, out_start, out_done;
    logic [13:0] stage_data;
    logic [13:0] dly_units;
    logic [15:0] cycle_count;

    logic [15:0] mem [0:PL-1];
    logic        preload;
    int          ev_cnt, ow_cnt, cyc;
    logic        in_a, in_b, in_c;
    int          checks = 0, fails = 0;

    always #10 clk = ~clk;

    emu_scan_seq #(.PROG_LEN(PL), .TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .in_addr(in_addr),
        .in_rdata(in_rdata), .eval_start(eval_start), .eval_done(eval_done),
        .out_start(out_start), .out_done(out_done), .stage_data(stage_data),
        .dly_units(dly_units), .cycle_count(cycle_count)
    );

    function automatic logic [15:0] mk(bit f, bit [1:0] k, bit [3:0] l, bit [7:0] lk, bit v);
        return {f, k, l, lk, v};
    endfunction

    function automatic logic [15:0] init_word(int k);
        case (k)
            0: return mk(0, 2'b00, 4'd1,  8'd3, 0);   // input bit0 (a)
            1: return mk(0, 2'b00, 4'd2,  8'd3, 0);   // input bit1 (b)
            2: return mk(0, 2'b00, 4'd0,  8'd5, 0);   // state read of word 5
            3: return mk(1, 2'b11, 4'd2,  8'hAA, 1);  // function word
            4: return mk(0, 2'b10, 4'd1,  8'd0, 1);   // out bit0 = a&b
            5: return mk(0, 2'b11, 4'd2,  8'd0, 1);   // state q, out bit1
            6: return mk(0, 2'b10, 4'd0,  8'd0, 1);   // internal a|b
            7: return mk(0, 2'b00, 4'd14, 8'd3, 0);   // input bit13 (c)
            8: return mk(0, 2'b10, 4'd14, 8'd0, 1);   // out bit13 = c
            default: return mk(0, 2'b01, 4'd3, 8'd3, 1); // indirect read
        endcase
    endfunction

    assign mem_rdata = mem[mem_addr];
    assign in_rdata  = (in_addr == 8'd3) ? {in_c, 10'b0, 1'b0, in_b, in_a} : 14'd0;
    assign eval_done = (ev_cnt == 1);
    assign out_done  = (ow_cnt == 1);

    // memory plus evaluator model
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (preload) begin
            for (int k = 0; k < PL; k++) mem[k] <= init_word(k);
            ev_cnt <= 0;
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            if (eval_start) ev_cnt <= 3;
            else if (ev_cnt != 0) ev_cnt <= ev_cnt - 1;
            if (ev_cnt == 1) begin
                mem[4][0] <= mem[0][0] & mem[1][0];
                mem[5][0] <= mem[2][0] ^ mem[0][0];
                mem[6][0] <= mem[0][0] | mem[1][0];
                mem[8][0] <= mem[7][0];
            end
        end
    end

    // output writer model
    always @(posedge clk) begin
        if (preload) ow_cnt <= 0;
        else if (out_start) ow_cnt <= 2;
        else if (ow_cnt != 0) ow_cnt <= ow_cnt - 1;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        bit   a_s [0:9], b_s [0:9], c_s [0:9];
        int   u_s [0:9];
        bit   q;
        int   t_prev, len_prev, len_now;
        logic [15:0] prev_cc;
        logic [13:0] exp_stage;

        for (int i = 0; i < 10; i++) begin
            a_s[i] = (i < 8) ? i[0] : (i == 9);
            b_s[i] = (i < 8) ? i[1] : 1'b0;
            c_s[i] = (i < 8) ? i[2] : (i == 9);
            u_s[i] = (i < 5) ? i : ((i == 5) ? 9999 : 2);
        end
        cyc = 0; rst = 1'b1; preload = 1'b1; dly_units = '0;
        in_a = a_s[0]; in_b = b_s[0]; in_c = c_s[0];
        repeat (3) @(negedge clk);
        // R9 R12: reset state
        chk("R9 count at reset", cycle_count, 0);
        chk("R12 stage at reset", stage_data, 0);
        chk("R7 no request in reset", {eval_start, out_start, mem_we}, 0);
        rst = 1'b0; preload = 1'b0;
        q = 1'b0; t_prev = 0; len_prev = 0;

        for (int i = 0; i < 10; i++) begin
            do @(negedge clk); while (!eval_start);
            if (i == 0) begin
                // R1: write values cleared, other fields kept
                chk("R1 word4", mem[4], init_word(4) & 16'hFFFE);
                chk("R1 word6", mem[6], init_word(6) & 16'hFFFE);
                chk("R1 word8", mem[8], init_word(8) & 16'hFFFE);
                chk("R1 word5 state", mem[5], init_word(5) & 16'hFFFE);
            end
            chk("R3 input bit0", mem[0][0], a_s[i]);
            chk("R3 input bit1", mem[1][0], b_s[i]);
            chk("R3 input bit13 (location 14)", mem[7][0], c_s[i]);
            chk("R4 state copy", mem[2][0], q);
            if (i == 8) in_c = 1'b1;   // R10: change during evaluation
            @(negedge clk);
            chk("R7 eval pulse one cycle", eval_start, 0);
            chk("R7 no write during eval", mem_we, 0);

            do @(negedge clk); while (!out_start);
            exp_stage = '0;
            exp_stage[0]  = a_s[i] & b_s[i];
            exp_stage[1]  = q;
            exp_stage[13] = c_s[i];
            chk((i >= 8) ? "R10 R5 R6 staged outputs" : "R2 R5 R6 staged outputs",
                stage_data, exp_stage);
            q = q ^ a_s[i];
            dly_units = 14'(u_s[i]);
            if (i < 9) begin
                in_a = a_s[i+1]; in_b = b_s[i+1]; in_c = c_s[i+1];
            end
            @(negedge clk);
            chk("R7 out pulse one cycle", out_start, 0);

            prev_cc = cycle_count;
            do @(negedge clk); while (cycle_count == prev_cc);
            chk("R9 loop count", cycle_count, i + 1);
            len_now = cyc - t_prev;
            if (i >= 2)
                chk("R8 delay length", len_now - len_prev, DIV * (u_s[i] - u_s[i-1]));
            len_prev = len_now;
            t_prev = cyc;
        end

        // R11: function and indirect words untouched
        chk("R11 function word", mem[3], init_word(3));
        chk("R11 indirect word", mem[9], init_word(9));

        // R12: reset in mid-loop
        do @(negedge clk); while (!eval_start);
        repeat (2) @(negedge clk);
        rst = 1'b1; preload = 1'b1;
        in_a = 1'b1; in_b = 1'b1; in_c = 1'b0;
        repeat (2) @(negedge clk);
        chk("R12 count cleared", cycle_count, 0);
        chk("R12 stage cleared", stage_data, 0);
        rst = 1'b0; preload = 1'b0;
        do @(negedge clk); while (!eval_start);
        chk("R12 state value recleared", mem[5][0], 0);
        chk("R12 plain value recleared", mem[4][0], 0);
        do @(negedge clk); while (!out_start);
        chk("R12 first loop output", stage_data, 14'h0001);

        summary();
        $finish;
    end
endmodule